// File: doc/BRIEF.md
# Multithreaded Issue Replay Controller

This block decides which hardware thread issues into a short shared pipeline and handles long-latency events without stalling. Each cycle a round-robin pick among the ready threads sends one instruction, tagged with its thread and program counter, into a four-stage pipe. Independent work from the same thread can follow back to back, one per cycle. No dependence checking is modelled: every instruction is treated as independent, or as resolved by forwarding.

When the execute-stage model flags a long-latency event on the instruction in the third stage, the controller does not freeze the pipe. It drops that instruction and every younger one from the same thread. It parks the thread with the faulting PC saved, and in that same cycle gives the issue slot to another ready thread. A later wake pulse makes the parked thread ready again, and it resumes by re-issuing the saved PC. Two saturating counters record the work done. One counts issue slots used, replays included. The other counts instructions that leave the last stage.

Top module: `replay_ctrl`

## Requirements
- R1: After reset, the issue, execute and retire outputs are invalid, no thread is parked and both counters read zero.
- R2: A thread that is ready and alone issues one instruction per cycle. Its first PC is the value held on its start-PC input while it was idle, and each later PC is 4 higher.
- R3: Among several ready threads the grant rotates. It goes to the first ready thread with a higher index than the last granted one, wrapping around. After reset, thread 0 has first priority.
- R4: An instruction shown on the issue outputs appears on the execute outputs two cycles later and on the retire outputs three cycles later. The completed counter is one higher in the cycle after retire_valid_o.
- R5: An event raised while ex_valid_o is high removes the execute-stage instruction and the younger instructions of the same thread from the pipe. Instructions of other threads keep flowing. The faulting instruction is not retired.
- R6: In the cycle of an event, the faulting thread is not selected. Another ready thread issues in that cycle; if there is none, nothing issues.
- R7: From the cycle after an event, the faulting thread shows parked_o high and issues nothing until a wake pulse.
- R8: After a wake, the first PC the thread issues is the PC of the instruction that faulted.
- R9: When no thread is ready, nothing issues and the issued counter holds its value.
- R10: The issued counter rises once per issue, replays included. The completed counter rises once per retired instruction. The issued count never falls below the completed count.
- R11: Both counters stop at their maximum value of 2^CNT_W-1 and do not wrap.
- R12: A wake that arrives in the same cycle as an event for the same thread is ignored. The thread stays parked until a later wake.
- R13: A thread whose instruction-valid input is low does not issue. While it is idle, its PC follows its start-PC input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | NUM_THR | Thread has an instruction available |
| start_pc_i | input | NUM_THR x PC_W | PC a thread begins from when it leaves idle |
| evt_i | input | 1 | Long-latency event on the execute-stage instruction |
| wake_i | input | NUM_THR | Pulse that releases a parked thread |
| issue_valid_o | output | 1 | First stage holds an instruction |
| issue_tid_o | output | TID_W | Thread of first-stage instruction |
| issue_pc_o | output | PC_W | PC of first-stage instruction |
| ex_valid_o | output | 1 | Execute stage holds an instruction |
| ex_tid_o | output | TID_W | Thread of execute-stage instruction |
| ex_pc_o | output | PC_W | PC of execute-stage instruction |
| retire_valid_o | output | 1 | Last stage holds a completing instruction |
| retire_tid_o | output | TID_W | Thread of retiring instruction |
| retire_pc_o | output | PC_W | PC of retiring instruction |
| parked_o | output | NUM_THR | Thread is parked waiting for a wake |
| issued_cnt_o | output | CNT_W | Saturating count of issues |
| done_cnt_o | output | CNT_W | Saturating count of completions |

## Verification
The checks treat evt_i as meaningful only while ex_valid_o is high, and the design ignores it otherwise. They assume that only the execute-stage model drives it and that a thread is not both squashed and already parked. The stimulus raises evt_i only in cycles where the execute outputs hold the instruction meant to fault. It sends wake pulses only to parked threads, apart from the deliberate collision case. All inputs change on the falling edge, so each rising edge sees settled values.

// File: rtl/replay_pkg.sv
package replay_pkg;
  localparam int PIPE_DEPTH = 4;
  localparam int EVT_STAGE  = 2;  // third stage reports events

  typedef enum logic [1:0] {
    THR_IDLE   = 2'd0,
    THR_READY  = 2'd1,
    THR_PARKED = 2'd2
  } thr_state_e;
endpackage

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int   c;
    logic found;
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr_q) + 1 + k;
      if (c >= N) c = c - N;
      if (!found && req_i[c]) begin
        gnt_o[c]  = 1'b1;
        gnt_idx_o = IDX_W'(c);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= IDX_W'(N - 1);
    else if (|req_i)  ptr_q <= gnt_idx_o;
  end

  // R3
  gnt_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0) && $onehot0(gnt_o) && ((|req_i) == (|gnt_o)));
endmodule

// File: rtl/thread_ctx.sv
module thread_ctx
  import replay_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] start_pc_i,
  input  logic            issue_i,
  input  logic            squash_i,
  input  logic [PC_W-1:0] squash_pc_i,
  input  logic            wake_i,
  output logic            ready_o,
  output logic            parked_o,
  output logic [PC_W-1:0] pc_o
);
  thr_state_e      st_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= THR_IDLE;
      pc_q <= '0;
    end else if (squash_i) begin
      st_q <= THR_PARKED;        // squash beats a same-cycle wake
      pc_q <= squash_pc_i;
    end else begin
      unique case (st_q)
        THR_IDLE: begin
          pc_q <= start_pc_i;
          if (valid_i) st_q <= THR_READY;
        end
        THR_READY: begin
          if (issue_i)       pc_q <= pc_q + PC_W'(PC_STEP);
          else if (!valid_i) st_q <= THR_IDLE;
        end
        THR_PARKED: if (wake_i) st_q <= THR_READY;
        default: st_q <= THR_IDLE;
      endcase
    end
  end

  assign ready_o  = (st_q == THR_READY) && valid_i;
  assign parked_o = (st_q == THR_PARKED);
  assign pc_o     = pc_q;

  // R7
  parked_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_o |-> !issue_i);
  // R12
  squash_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i && wake_i |=> parked_o);
  // R8
  parked_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_o && !wake_i && !squash_i |=> parked_o && $stable(pc_o));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R11
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == MAX |=> cnt_q == MAX);
endmodule

// File: rtl/replay_ctrl.sv
module replay_ctrl
  import replay_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter int CNT_W   = 32,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_THR-1:0]            instr_valid_i,
  input  logic [NUM_THR-1:0][PC_W-1:0]  start_pc_i,
  input  logic                          evt_i,
  input  logic [NUM_THR-1:0]            wake_i,
  output logic                          issue_valid_o,
  output logic [TID_W-1:0]              issue_tid_o,
  output logic [PC_W-1:0]               issue_pc_o,
  output logic                          ex_valid_o,
  output logic [TID_W-1:0]              ex_tid_o,
  output logic [PC_W-1:0]               ex_pc_o,
  output logic                          retire_valid_o,
  output logic [TID_W-1:0]              retire_tid_o,
  output logic [PC_W-1:0]               retire_pc_o,
  output logic [NUM_THR-1:0]            parked_o,
  output logic [CNT_W-1:0]              issued_cnt_o,
  output logic [CNT_W-1:0]              done_cnt_o
);
  typedef struct packed {
    logic             vld;
    logic [TID_W-1:0] tid;
    logic [PC_W-1:0]  pc;
  } slot_t;

  slot_t [PIPE_DEPTH-1:0]       pipe_q, pipe_d;
  logic [NUM_THR-1:0]           ready_vec, squash_vec, req_vec, gnt_vec;
  logic [NUM_THR-1:0][PC_W-1:0] pc_vec;
  logic [TID_W-1:0]             gnt_idx, sq_tid;
  logic                         evt_vld, issue_en;

  assign evt_vld = evt_i && pipe_q[EVT_STAGE].vld;
  assign sq_tid  = pipe_q[EVT_STAGE].tid;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign squash_vec[t] = evt_vld && (sq_tid == TID_W'(t));
    thread_ctx #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_ctx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (instr_valid_i[t]),
      .start_pc_i  (start_pc_i[t]),
      .issue_i     (gnt_vec[t]),
      .squash_i    (squash_vec[t]),
      .squash_pc_i (pipe_q[EVT_STAGE].pc),
      .wake_i      (wake_i[t]),
      .ready_o     (ready_vec[t]),
      .parked_o    (parked_o[t]),
      .pc_o        (pc_vec[t])
    );
  end

  // faulting thread may not take the slot it just vacated
  assign req_vec = ready_vec & ~squash_vec;

  rr_arb #(.N(NUM_THR)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_vec),
    .gnt_o     (gnt_vec),
    .gnt_idx_o (gnt_idx)
  );

  assign issue_en = |gnt_vec;

  always_comb begin
    pipe_d[0].vld = issue_en;
    pipe_d[0].tid = gnt_idx;
    pipe_d[0].pc  = pc_vec[gnt_idx];
    for (int s = 1; s < PIPE_DEPTH; s++) begin
      pipe_d[s] = pipe_q[s-1];
      // faulting stage and all younger slots of that thread
      if (evt_vld && (s - 1) <= EVT_STAGE && pipe_q[s-1].tid == sq_tid)
        pipe_d[s].vld = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  sat_counter #(.W(CNT_W)) u_issued_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (issue_en), .cnt_o (issued_cnt_o)
  );
  sat_counter #(.W(CNT_W)) u_done_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (pipe_q[PIPE_DEPTH-1].vld), .cnt_o (done_cnt_o)
  );

  assign issue_valid_o  = pipe_q[0].vld;
  assign issue_tid_o    = pipe_q[0].tid;
  assign issue_pc_o     = pipe_q[0].pc;
  assign ex_valid_o     = pipe_q[EVT_STAGE].vld;
  assign ex_tid_o       = pipe_q[EVT_STAGE].tid;
  assign ex_pc_o        = pipe_q[EVT_STAGE].pc;
  assign retire_valid_o = pipe_q[PIPE_DEPTH-1].vld;
  assign retire_tid_o   = pipe_q[PIPE_DEPTH-1].tid;
  assign retire_pc_o    = pipe_q[PIPE_DEPTH-1].pc;

  // R5
  squash_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld |=> !retire_valid_o);
  // R6
  switch_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_vld |=> !(issue_valid_o && issue_tid_o == $past(sq_tid)));
  // R9
  idle_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ready_vec) |=> !issue_valid_o);
  // R10
  count_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issued_cnt_o >= done_cnt_o);
endmodule

// File: tb/replay_ctrl_bench.sv
module replay_ctrl_bench;
  localparam int NT = 4;
  localparam int PW = 32;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]         valid;
  logic [NT-1:0][PW-1:0] spc;
  logic                  evt;
  logic [NT-1:0]         wake;

  logic          iv, xv, rv, iv_s, xv_s, rv_s;
  logic [TW-1:0] it, xt, rt, it_s, xt_s, rt_s;
  logic [PW-1:0] ip, xp, rp, ip_s, xp_s, rp_s;
  logic [NT-1:0] parked, parked_s;
  logic [31:0]   icnt, dcnt;
  logic [3:0]    icnt_s, dcnt_s;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  replay_ctrl u_replay_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .start_pc_i(spc),
    .evt_i(evt), .wake_i(wake),
    .issue_valid_o(iv), .issue_tid_o(it), .issue_pc_o(ip),
    .ex_valid_o(xv), .ex_tid_o(xt), .ex_pc_o(xp),
    .retire_valid_o(rv), .retire_tid_o(rt), .retire_pc_o(rp),
    .parked_o(parked), .issued_cnt_o(icnt), .done_cnt_o(dcnt)
  );

  replay_ctrl #(.CNT_W(4)) u_replay_ctrl_sat (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .start_pc_i(spc),
    .evt_i(evt), .wake_i(wake),
    .issue_valid_o(iv_s), .issue_tid_o(it_s), .issue_pc_o(ip_s),
    .ex_valid_o(xv_s), .ex_tid_o(xt_s), .ex_pc_o(xp_s),
    .retire_valid_o(rv_s), .retire_tid_o(rt_s), .retire_pc_o(rp_s),
    .parked_o(parked_s), .issued_cnt_o(icnt_s), .done_cnt_o(dcnt_s)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = '0; evt = 1'b0; wake = '0;
    spc = '0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wait_issue(string req);
    int k;
    k = 0;
    step();
    while (!iv && k < 10) begin step(); k++; end
    chk(req, "issue seen", iv, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "issue_valid", iv, 0);
    chk("R1", "ex_valid", xv, 0);
    chk("R1", "retire_valid", rv, 0);
    chk("R1", "parked", parked, 0);
    chk("R1", "issued", icnt, 0);
    chk("R1", "done", dcnt, 0);
  endtask

  task automatic t_single();
    do_reset();
    spc[0] = 32'h50;
    step(); step();
    chk("R13", "no issue while idle", iv, 0);
    spc[0] = 32'h100;
    valid[0] = 1'b1;
    wait_issue("R2");
    chk("R13", "start pc followed", ip, 32'h100);
    chk("R10", "issued after 1", icnt, 1);
    step();
    chk("R2", "pc +4", ip, 32'h104);
    step();
    chk("R2", "pc +8", ip, 32'h108);
    chk("R4", "ex pc 2 later", xp, 32'h100);
    valid[0] = 1'b0;
    step();
    chk("R13", "no issue after valid low", iv, 0);
    chk("R4", "retire valid", rv, 1);
    chk("R4", "retire pc 3 later", rp, 32'h100);
    chk("R4", "done before bump", dcnt, 0);
    step();
    chk("R4", "done bumped", dcnt, 1);
    step(); step();
    chk("R10", "issued total", icnt, 3);
    chk("R10", "done total", dcnt, 3);
  endtask

  task automatic t_rr();
    do_reset();
    spc[0] = 32'h1100; spc[1] = 32'h2200; spc[2] = 32'h3300;
    valid[2:0] = 3'b111;
    wait_issue("R3");
    chk("R3", "first tid", it, 0);
    for (int i = 1; i < 6; i++) begin
      step();
      chk("R3", "rotating tid", it, i % 3);
      chk("R3", "rotating pc", ip, spc[i % 3] + 32'(4 * (i / 3)));
    end
    valid = '0;
  endtask

  task automatic t_replay_alone();
    logic [31:0] a;
    a = 32'h4000;
    do_reset();
    spc[0] = a;
    valid[0] = 1'b1;
    wait_issue("R5");
    chk("R2", "first pc", ip, a);
    step(); step();
    chk("R5", "ex holds target", xp, a);
    evt = 1'b1; wake[0] = 1'b1;
    step();
    evt = 1'b0; wake[0] = 1'b0;
    chk("R6", "no other ready: no issue", iv, 0);
    chk("R5", "ex cleared", xv, 0);
    chk("R5", "no retire", rv, 0);
    chk("R12", "stays parked", parked[0], 1);
    chk("R10", "issued counts squashed", icnt, 3);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7", "parked holds", parked[0], 1);
      chk("R9", "no issue", iv, 0);
      chk("R5", "nothing retires", rv, 0);
    end
    chk("R9", "issued frozen", icnt, 3);
    wake[0] = 1'b1;
    step();
    wake[0] = 1'b0;
    chk("R7", "released", parked[0], 0);
    step();
    chk("R8", "replay pc", ip, a);
    chk("R10", "replay counted", icnt, 4);
    step();
    chk("R8", "next after replay", ip, a + 4);
    valid[0] = 1'b0;
    step(); step();
    chk("R5", "faulting retires after replay", rp, a);
    step();
    chk("R5", "next retires", rp, a + 4);
    step();
    chk("R10", "issued with replays", icnt, 5);
    chk("R10", "done", dcnt, 2);
  endtask

  task automatic t_switch();
    logic [31:0] a, b;
    a = 32'h6000; b = 32'h7000;
    do_reset();
    spc[0] = a; spc[1] = b;
    valid[1:0] = 2'b11;
    wait_issue("R6");
    chk("R3", "t0 first", it, 0);
    step(); step();
    chk("R5", "ex tid 0", xt, 0);
    chk("R5", "ex pc", xp, a);
    evt = 1'b1;
    step();
    evt = 1'b0;
    chk("R6", "switch tid", it, 1);
    chk("R6", "switch pc", ip, b + 4);
    chk("R5", "other thread kept", xv, 1);
    chk("R5", "kept pc", xp, b);
    chk("R7", "t0 parked", parked[0], 1);
    chk("R5", "no retire of fault", rv, 0);
    step();
    chk("R7", "t1 keeps slot", ip, b + 8);
    chk("R5", "other retires", rp, b);
    chk("R5", "younger t0 removed", xv, 0);
    valid = '0;
  endtask

  task automatic t_sat();
    int seen;
    seen = 0;
    do_reset();
    spc[0] = 32'h8000;
    valid[0] = 1'b1;
    repeat (25) begin
      step();
      if (iv) seen++;
    end
    valid[0] = 1'b0;
    repeat (6) step();
    chk("R10", "issued matches", icnt, 64'(seen));
    chk("R10", "done matches", dcnt, 64'(seen));
    chk("R11", "narrow issued saturates", icnt_s, 15);
    chk("R11", "narrow done saturates", dcnt_s, 15);
  endtask

  initial begin
    valid = '0; evt = 1'b0; wake = '0; spc = '0;
    t_reset();
    t_single();
    t_rr();
    t_replay_alone();
    t_switch();
    t_sat();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule